// File: doc/BRIEF.md
# Timer-Driven Pulse-Width Modulator

This block produces a fixed-frequency pulse train with a 10-bit high time. An 8-bit timer counts instruction cycles. One instruction cycle is four clocks, and the timer sits behind a prescaler that divides by 1, 4 or 16. When the timer reaches the programmed period value it returns to zero, and a new cycle of the waveform begins. Inside each instruction cycle a 2-bit sub-count marks the quarter that has elapsed. The timer value joined with this sub-count forms a 10-bit position, and that position is compared with the 10-bit high time.

Software programs the block through a write strobe with a 2-bit address and 8-bit data. Once enabled, the waveform runs with no further writes. A new high time is held in a buffer and takes effect only at the next period boundary. A postscaler counts period boundaries and emits a one-clock tick every N-th boundary, so that a periodic sampling routine can be paced from the timer. The postscaler has no effect on the waveform.

Top module: `pwm_timer_gen`

## Requirements
- R1: After reset all settings are zero, `pwmOut` is 0 and `tickIrq` is 0.
- R2: The waveform period is (P+1)×4×S clocks. P is the period value (address 0). S is 1, 4 or 16 for settings field bits [5:4] = 0, 1 or 2 (3 also gives 16).
- R3: The 10-bit high time D is formed from the address-1 byte (upper 8 bits) and settings bits [1:0] (lower 2 bits). The output is high for the first D×S clocks of each period and low for the rest.
- R4: When D is 0, the output stays low for the whole period.
- R5: When D is at least 4×(P+1), the output stays high for the whole period.
- R6: While the timer runs, a new D takes effect at the first period boundary after the write. A write that lands on the boundary clock edge takes effect one period later. While the timer is stopped, a written D is adopted one clock later.
- R7: The output is driven only when settings bits [3:2] are both 1. In any other mode the output is low, while the timer and the tick keep running.
- R8: While settings bit 6 (enable) is 0, the timer, sub-count and postscaler are held at zero, the output is low and no tick is issued.
- R9: With the address-3 value Q (bits [3:0]), `tickIrq` is a one-clock pulse. It is issued at every (Q+1)-th period boundary after enable, in the first clock of the new period.
- R10: The postscale setting does not change the waveform period or its high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 period, 1 duty upper byte, 2 settings, 3 postscale |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | Modulated output |
| tickIrq | output | 1 | Postscaled period tick, one clock wide |

## Verification
A duty write and a period boundary can fall on the same clock edge. At that edge the buffered value is copied into the active compare register while the buffer itself is being overwritten. The bench provokes this by counting clocks from enable and placing the write strobe exactly on the edge where the timer wraps. It judges the result by the high-clock count of the next two periods: the old high time must appear once more, and only then the new one. The tick and the duty transfer also share the boundary edge. The bench therefore checks the tick's position within the sampled window while the waveform is measured in the same window.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  typedef struct packed {
    logic clear;  // timer stopped: hold counters at zero
    logic step;   // instruction-cycle (prescaled) advance
    logic wrap;   // period match: restart and reload duty
  } tmr_strobe_t;

  typedef enum logic [1:0] {
    ADDR_PERIOD  = 2'd0,
    ADDR_DUTY_HI = 2'd1,
    ADDR_CTRL    = 2'd2,
    ADDR_POST    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
#(
  parameter int SUB_W   = 2,
  parameter int PRE_LOG = 4,
  parameter int PS_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       preSel,
  input  logic [PS_W-1:0]  postSel,
  input  logic             periodHit,
  output tmr_strobe_t      strobe,
  output logic [SUB_W-1:0] subCount,
  output logic             tickIrq
);
  localparam int FINE_W = SUB_W + PRE_LOG;

  logic [FINE_W-1:0] fineQ;
  logic [FINE_W-1:0] fineLast;
  logic [PS_W-1:0]   postCnt;
  int                shift;

  always_comb begin
    case (preSel)
      2'd0:    shift = 0;
      2'd1:    shift = 2;
      default: shift = 4;
    endcase
    fineLast = FINE_W'((1 << (SUB_W + shift)) - 1);
    subCount = SUB_W'(fineQ >> shift);
  end

  always_comb begin
    strobe.clear = !enable;
    strobe.step  = enable && (fineQ == fineLast);
    strobe.wrap  = enable && (fineQ == fineLast) && periodHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fineQ <= '0;
    end else if (strobe.clear || strobe.step) begin
      fineQ <= '0;
    end else begin
      fineQ <= fineQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      postCnt <= '0;
      tickIrq <= 1'b0;
    end else if (strobe.clear) begin
      postCnt <= '0;
      tickIrq <= 1'b0;
    end else begin
      tickIrq <= strobe.wrap && (postCnt == postSel);
      if (strobe.wrap) begin
        postCnt <= (postCnt == postSel) ? '0 : postCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_gen_datapath.sv
module pwm_gen_datapath
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  parameter int PS_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [TMR_W-1:0]       wrData,
  input  tmr_strobe_t            strobe,
  input  logic [SUB_W-1:0]       subCount,
  output logic                   enable,
  output logic [1:0]             preSel,
  output logic [1:0]             modeBits,
  output logic [PS_W-1:0]        postSel,
  output logic                   periodHit,
  output logic [TMR_W-1:0]       tmrQ,
  output logic [TMR_W+SUB_W-1:0] dutyLatch,
  output logic                   pwmOut
);
  localparam int DUTY_W = TMR_W + SUB_W;

  logic [TMR_W-1:0] periodQ;
  logic [TMR_W-1:0] dutyHiQ;
  logic [SUB_W-1:0] dutyLoQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodQ  <= '0;
      dutyHiQ  <= '0;
      dutyLoQ  <= '0;
      modeBits <= '0;
      preSel   <= '0;
      enable   <= 1'b0;
      postSel  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD:  periodQ <= wrData;
        ADDR_DUTY_HI: dutyHiQ <= wrData;
        ADDR_CTRL: begin
          dutyLoQ  <= wrData[SUB_W-1:0];
          modeBits <= wrData[3:2];
          preSel   <= wrData[5:4];
          enable   <= wrData[6];
        end
        default:      postSel <= wrData[PS_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrQ      <= '0;
      dutyLatch <= '0;
    end else begin
      if (strobe.clear || strobe.wrap) begin
        tmrQ <= '0;
      end else if (strobe.step) begin
        tmrQ <= tmrQ + 1'b1;
      end
      if (strobe.clear || strobe.wrap) begin
        dutyLatch <= {dutyHiQ, dutyLoQ};
      end
    end
  end

  logic [DUTY_W-1:0] position;
  assign position  = {tmrQ, subCount};
  assign periodHit = (tmrQ == periodQ);
  assign pwmOut    = enable && (modeBits == 2'b11) && (position < dutyLatch);
endmodule

// File: rtl/pwm_timer_gen.sv
module pwm_timer_gen
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int SUB_W   = 2,
  parameter int PRE_LOG = 4,
  parameter int PS_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [TMR_W-1:0] wrData,
  output logic             pwmOut,
  output logic             tickIrq
);
  tmr_strobe_t             strobe;
  logic                    enable;
  logic [1:0]              preSel;
  logic [1:0]              modeBits;
  logic [PS_W-1:0]         postSel;
  logic                    periodHit;
  logic [SUB_W-1:0]        subCount;
  logic [TMR_W-1:0]        tmrQ;
  logic [TMR_W+SUB_W-1:0]  dutyLatch;

  pwm_gen_ctrl #(.SUB_W(SUB_W), .PRE_LOG(PRE_LOG), .PS_W(PS_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .preSel(preSel),
    .postSel(postSel), .periodHit(periodHit), .strobe(strobe),
    .subCount(subCount), .tickIrq(tickIrq)
  );

  pwm_gen_datapath #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PS_W(PS_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .subCount(subCount), .enable(enable), .preSel(preSel),
    .modeBits(modeBits), .postSel(postSel), .periodHit(periodHit),
    .tmrQ(tmrQ), .dutyLatch(dutyLatch), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic [1:0]             modeBits,
  input logic [TMR_W-1:0]       tmrQ,
  input logic [SUB_W-1:0]       subCount,
  input logic [TMR_W+SUB_W-1:0] dutyLatch,
  input logic                   pwmOut,
  input logic                   tickIrq
);
  AST_TICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |=> !tickIrq); // R9
  AST_TICK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> (tmrQ == '0 && subCount == '0)); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pwmOut); // R8
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(!enable)) |-> !tickIrq); // R8
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBits != 2'b11) |-> !pwmOut); // R7
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !(tmrQ == '0 && subCount == '0)) |-> $stable(dutyLatch)); // R6
endmodule

bind pwm_timer_gen pwm_gen_checker #(.TMR_W(TMR_W), .SUB_W(SUB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .modeBits(modeBits),
  .tmrQ(tmrQ), .subCount(subCount), .dutyLatch(dutyLatch),
  .pwmOut(pwmOut), .tickIrq(tickIrq)
);

// File: tb/pwm_timer_gen_tb.sv
module pwm_timer_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut;
  logic       tickIrq;
  int         checks = 0;
  int         errors = 0;

  pwm_timer_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .tickIrq(tickIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sampleWindow(input int n, output int highs, output int ticks,
                              output int firstTick);
    highs = 0; ticks = 0; firstTick = -1;
    for (int i = 0; i < n; i++) begin
      if (pwmOut) highs++;
      if (tickIrq) begin
        if (firstTick < 0) firstTick = i;
        ticks++;
      end
      @(negedge clk);
    end
  endtask

  // settings byte: [6] enable, [5:4] prescale, [3:2] mode, [1:0] duty low
  task automatic setup(input int pr, input int dHi, input int dLo, input int mode,
                       input int pre, input int post);
    logic [7:0] cfg;
    cfg = {1'b0, 1'b0, 2'(pre), 2'(mode), 2'(dLo)};
    wrReg(2'd2, 8'h00);
    wrReg(2'd0, 8'(pr));
    wrReg(2'd1, 8'(dHi));
    wrReg(2'd3, 8'(post));
    wrReg(2'd2, cfg);
    wrReg(2'd2, cfg | 8'h40);
  endtask

  task automatic t_reset();
    check("R1 pwmOut after reset", int'(pwmOut), 0);
    check("R1 tickIrq after reset", int'(tickIrq), 0);
  endtask

  task automatic t_prescale(input string tag, input int pr, input int dHi, input int dLo,
                            input int pre, input int s);
    int p, h, t, f;
    p = (pr + 1) * 4 * s;
    setup(pr, dHi, dLo, 3, pre, 0);
    sampleWindow(p, h, t, f);
    check({tag, " R3 high clocks first period"}, h, (dHi * 4 + dLo) * s);
    check({tag, " R2 no tick inside first period"}, t, 0);
    sampleWindow(p, h, t, f);
    check({tag, " R3 high clocks second period"}, h, (dHi * 4 + dLo) * s);
    check({tag, " R2 tick at period start"}, f, 0);
  endtask

  task automatic t_zero();
    int h, t, f;
    setup(9, 0, 0, 3, 0, 0);
    sampleWindow(80, h, t, f);
    check("R4 zero duty stays low", h, 0);
  endtask

  task automatic t_full();
    int h, t, f;
    setup(3, 4, 0, 3, 0, 0);
    sampleWindow(32, h, t, f);
    check("R5 duty equal to period stays high", h, 32);
    setup(3, 255, 3, 3, 0, 0);
    sampleWindow(32, h, t, f);
    check("R5 max duty stays high", h, 32);
  endtask

  task automatic t_mode();
    int h, t, f;
    setup(9, 3, 1, 1, 0, 0);
    sampleWindow(40, h, t, f);
    sampleWindow(40, h, t, f);
    check("R7 non-PWM mode output low", h, 0);
    check("R7 timer tick still runs", t, 1);
  endtask

  task automatic t_disable();
    int h, t, f;
    setup(9, 3, 1, 3, 0, 0);
    wrReg(2'd2, 8'h0D);
    sampleWindow(100, h, t, f);
    check("R8 disabled output low", h, 0);
    check("R8 disabled no tick", t, 0);
  endtask

  task automatic t_midWrite();
    int h1, h2, t, f;
    setup(9, 3, 1, 3, 0, 0);
    sampleWindow(20, h1, t, f);
    wrReg(2'd1, 8'd6);
    sampleWindow(19, h2, t, f);
    check("R6 mid-period write keeps old duty", h1 + h2, 13);
    sampleWindow(40, h1, t, f);
    check("R6 new duty next period", h1, 25);
  endtask

  task automatic t_collide();
    int h, t, f;
    setup(9, 3, 1, 3, 0, 0);
    sampleWindow(39, h, t, f);
    wrReg(2'd1, 8'd6);          // write edge equals the wrap edge
    sampleWindow(40, h, t, f);
    check("R6 boundary write old duty once more", h, 13);
    check("R9 tick beside boundary write", t, 1);
    sampleWindow(40, h, t, f);
    check("R6 boundary write adopted after one period", h, 25);
  endtask

  task automatic t_post();
    int h, t, f;
    setup(1, 0, 3, 3, 0, 2);
    sampleWindow(72, h, t, f);
    check("R9 tick count with postscale 3", t, 2);
    check("R9 first tick at third boundary", f, 24);
    check("R10 postscale leaves high time per period", h, 27);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale("pre1", 9, 3, 1, 0, 1);
    t_prescale("pre4", 4, 2, 2, 1, 4);
    t_prescale("pre16", 2, 1, 1, 2, 16);
    t_zero();
    t_full();
    t_mode();
    t_disable();
    t_midWrite();
    t_collide();
    t_post();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule